// File: doc/BRIEF.md
# System Address Decoder with Boot ROM Overlay

This block sits between a 24-bit CPU bus and the memories and peripherals of a small computer. On each strobed access it works out which region the address falls in: boot ROM, main RAM, video RAM, the page-table RAM or the general I/O space. It asserts exactly one select for that region and presents the byte offset inside the region, already masked to the region's size. It produces no read data of its own except the open-bus value, which is all ones at the width of the access, returned when a read falls into unclaimed I/O space.

At power-up a boot overlay is active. In that state address bit 23 is forced high before decoding, so every fetch, including the reset vector fetch at address zero, lands in ROM. Software clears the overlay by writing a control register that sits in I/O space. That register is reachable in both states because its address already has bit 23 set. The block also holds a four-bit, active-low LED register. Both registers are write-only and follow big-endian byte lane placement. All decoding is combinational, and only the two registers are clocked.

Top module: `sys_addr_decode`

## Requirements
- R1: After reset the overlay is active (the map-enable flag is 0) and the LED register holds 4'hF, so all LEDs are off.
- R2: While map-enable is 0, address bit 23 is forced to 1 before decoding. Any address with bit 22 clear therefore selects ROM, with offset (addr | 0x800000) & (ROM_BYTES-1).
- R3: Effective addresses 0x800000 to 0xBFFFFF select ROM (select bit 0) with offset masked by ROM_BYTES-1. A write to ROM never raises the memory write enable.
- R4: Effective addresses below RAM_BYTES select RAM (select bit 1) with offset masked by RAM_BYTES-1. Addresses from RAM_BYTES up to 0x3FFFFF fall to I/O.
- R5: Video RAM, 0x420000 to 0x427FFF, uses select bit 2 and a 15-bit offset. Page-table RAM, 0x400000 to 0x4007FF, uses select bit 3 and an 11-bit offset. I/O is select bit 4, and its offset is the full effective address.
- R6: A strobed write to 0xE43000 loads map-enable. The source is data bit 15 for word (size code 1) and long (size code 2 or 3) writes, and data bit 7 for byte (size code 0) writes.
- R7: A strobed write to effective address 0x4A0000 loads the active-low LED register. Word writes take data bits 11:8. Byte writes take bits 3:0, because the even byte is the high byte of the word. Long writes take bits 27:24.
- R8: A strobed read that selects I/O returns 0xFF, 0xFFFF or 0xFFFFFFFF for byte, word or long size. In every other case the read data is 0.
- R9: The select vector is one-hot while the strobe is high and all zero while it is low. The memory write enable is high only for a strobed write that selects RAM, video RAM or page-table RAM.
- R10: No other access changes the registers. This includes writes to 0x4A0002, and an LED write issued while the overlay is active, which decodes to 0xCA0000 in I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| req_addr | input | 24 | CPU byte address |
| req_size | input | 2 | 0 byte, 1 word, 2/3 long |
| req_write | input | 1 | 1 for a write access |
| req_wdata | input | 32 | Write data, right-aligned to the access size |
| sel_o | output | 5 | One-hot region select: 0 ROM, 1 RAM, 2 video RAM, 3 page-table RAM, 4 I/O |
| region_off_o | output | 24 | Offset inside the selected region |
| mem_we_o | output | 1 | Write enable for the writable memories |
| rd_data_o | output | 32 | Open-bus read data |
| led_n_o | output | 4 | LED drive, active low |

## Verification
The hardest states to reach are those that depend on the overlay. The LED register and every region below 0x800000 exist only after software has cleared the overlay, and the only way to clear it is a correctly sized write to the control register. The bench therefore sweeps the whole 24-bit space, one probe per 4 KB page, twice: once with the overlay active and once after a byte-sized control write has cleared it. It then toggles the overlay back and forth using each size code in turn, to show which data bit each size code takes. Region edges are probed one byte either side of each boundary.

// File: rtl/adec_pkg.sv
package adec_pkg;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int NREG   = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        RG_ROM  = 3'd0,
        RG_RAM  = 3'd1,
        RG_VRAM = 3'd2,
        RG_PTAB = 3'd3,
        RG_IO   = 3'd4
    } region_e;

    localparam logic [ADDR_W-1:0] VRAM_LO   = 24'h420000;
    localparam logic [ADDR_W-1:0] VRAM_HI   = 24'h427FFF;
    localparam logic [ADDR_W-1:0] PTAB_LO   = 24'h400000;
    localparam logic [ADDR_W-1:0] PTAB_HI   = 24'h4007FF;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 24'hE43000;
    localparam logic [ADDR_W-1:0] LED_ADDR  = 24'h4A0000;
    localparam int               FORCE_BIT = 23;

    typedef struct packed {
        logic       map_en;
        logic [3:0] led_n;
    } ctrl_state_t;
endpackage

// File: rtl/adec_region.sv
module adec_region
    import adec_pkg::*;
#(
    parameter int RAM_BYTES = 32'h80000,
    parameter int ROM_BYTES = 32'h8000
) (
    input  logic [ADDR_W-1:0] eff_addr,
    output region_e           region,
    output logic [ADDR_W-1:0] offset
);
    localparam logic [ADDR_W-1:0] RAM_LIM  = ADDR_W'(RAM_BYTES);
    localparam logic [ADDR_W-1:0] RAM_MASK = ADDR_W'(RAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] ROM_MASK = ADDR_W'(ROM_BYTES - 1);
    localparam logic [ADDR_W-1:0] VRAM_MASK = VRAM_HI - VRAM_LO;
    localparam logic [ADDR_W-1:0] PTAB_MASK = PTAB_HI - PTAB_LO;

    logic [NREG-1:0]   hit;
    logic [ADDR_W-1:0] mask [NREG];

    assign hit[RG_ROM]  = (eff_addr[ADDR_W-1:ADDR_W-2] == 2'b10);
    assign hit[RG_RAM]  = (eff_addr < RAM_LIM);
    assign hit[RG_VRAM] = (eff_addr >= VRAM_LO) && (eff_addr <= VRAM_HI);
    assign hit[RG_PTAB] = (eff_addr >= PTAB_LO) && (eff_addr <= PTAB_HI);
    assign hit[RG_IO]   = 1'b1;

    assign mask[RG_ROM]  = ROM_MASK;
    assign mask[RG_RAM]  = RAM_MASK;
    assign mask[RG_VRAM] = VRAM_MASK;
    assign mask[RG_PTAB] = PTAB_MASK;
    assign mask[RG_IO]   = '1;

    // Fixed priority: lowest index wins
    always_comb begin
        region = RG_IO;
        for (int k = NREG - 1; k >= 0; k--) begin
            if (hit[k]) region = region_e'(k);
        end
    end

    assign offset = eff_addr & mask[region];
endmodule

// File: rtl/adec_ctrl.sv
module adec_ctrl
    import adec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_hit,
    input  logic              led_hit,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_state_t       state
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_hit) begin
            st_d.map_en = (size == SZ_BYTE) ? wdata[7] : wdata[15];
        end
        if (led_hit) begin
            unique case (size)
                SZ_BYTE: st_d.led_n = wdata[3:0];
                SZ_WORD: st_d.led_n = wdata[11:8];
                default: st_d.led_n = wdata[27:24];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.map_en <= 1'b0;
            st_q.led_n  <= 4'hF;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/sys_addr_decode.sv
module sys_addr_decode
    import adec_pkg::*;
#(
    parameter int RAM_BYTES = 32'h80000,
    parameter int ROM_BYTES = 32'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [23:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic [4:0]        sel_o,
    output logic [23:0]       region_off_o,
    output logic              mem_we_o,
    output logic [31:0]       rd_data_o,
    output logic [3:0]        led_n_o
);
    localparam int LANES = DATA_W / 8;

    ctrl_state_t       cst;
    logic              map_en_q;
    logic [ADDR_W-1:0] eff_addr;
    region_e           region;
    acc_size_e         size;
    logic              io_read;
    logic              wr_stb;
    int                lane_cnt;

    assign size     = acc_size_e'(req_size);
    assign map_en_q = cst.map_en;
    assign eff_addr = req_addr | (ADDR_W'(!map_en_q) << FORCE_BIT);
    assign wr_stb   = req_valid && req_write;

    adec_region #(
        .RAM_BYTES (RAM_BYTES),
        .ROM_BYTES (ROM_BYTES)
    ) i_region (
        .eff_addr (eff_addr),
        .region   (region),
        .offset   (region_off_o)
    );

    adec_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_hit (wr_stb && (eff_addr == CTRL_ADDR)),
        .led_hit  (wr_stb && (eff_addr == LED_ADDR)),
        .size     (size),
        .wdata    (req_wdata),
        .state    (cst)
    );

    assign sel_o    = req_valid ? (NREG'(1) << region) : '0;
    assign mem_we_o = wr_stb && (region == RG_RAM || region == RG_VRAM || region == RG_PTAB);
    assign io_read  = req_valid && !req_write && (region == RG_IO);
    assign led_n_o  = cst.led_n;

    always_comb begin
        unique case (size)
            SZ_BYTE: lane_cnt = 1;
            SZ_WORD: lane_cnt = 2;
            default: lane_cnt = LANES;
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rd_data_o[8*k +: 8] = (io_read && (k < lane_cnt)) ? 8'hFF : 8'h00;
    end
endmodule

// File: rtl/adec_checker.sv
module adec_checker
    import adec_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [23:0] req_addr,
    input logic [1:0]  req_size,
    input logic        req_write,
    input logic [31:0] req_wdata,
    input logic [4:0]  sel,
    input logic        mem_we,
    input logic [31:0] rd_data,
    input logic [3:0]  led_n,
    input logic        map_en
);
    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    assert_sel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (sel == 5'b0 && !mem_we));

    assert_rom_no_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel[0] |-> !mem_we);

    assert_boot_rom_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !map_en && !req_addr[22]) |-> (sel == 5'b00001));

    assert_ctrl_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == CTRL_ADDR && req_size == 2'd1)
        |=> (map_en == $past(req_wdata[15])));

    assert_led_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(led_n));

    assert_openbus_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sel[4] && req_size == 2'd0) |-> (rd_data == 32'h0000_00FF));
endmodule

bind sys_addr_decode adec_checker i_adec_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .sel       (sel_o),
    .mem_we    (mem_we_o),
    .rd_data   (rd_data_o),
    .led_n     (led_n_o),
    .map_en    (map_en_q)
);

// File: tb/test_sys_addr_decode.sv
module test_sys_addr_decode;
    localparam int CLK_PERIOD = 10;
    localparam int RAM_B = 32'h80000;
    localparam int ROM_B = 32'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [4:0]  sel_o;
    logic [23:0] region_off_o;
    logic        mem_we_o;
    logic [31:0] rd_data_o;
    logic [3:0]  led_n_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_addr_decode #(.RAM_BYTES(RAM_B), .ROM_BYTES(ROM_B)) i_sys_addr_decode (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_addr (req_addr),
        .req_size (req_size), .req_write (req_write), .req_wdata (req_wdata),
        .sel_o (sel_o), .region_off_o (region_off_o), .mem_we_o (mem_we_o),
        .rd_data_o (rd_data_o), .led_n_o (led_n_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic model(input logic [23:0] a, input bit m, input logic [1:0] sz, input bit wr,
                         output logic [4:0] s, output logic [23:0] off, output bit we,
                         output logic [31:0] rd, output string tag);
        logic [23:0] e;
        e = m ? a : (a | 24'h800000);
        if (e >= 24'h800000 && e <= 24'hBFFFFF) begin s = 5'b00001; off = e & 24'(ROM_B-1); tag = "R3"; end
        else if (e < 24'(RAM_B))                begin s = 5'b00010; off = e & 24'(RAM_B-1); tag = "R4"; end
        else if (e >= 24'h420000 && e <= 24'h427FFF) begin s = 5'b00100; off = e & 24'h7FFF; tag = "R5"; end
        else if (e >= 24'h400000 && e <= 24'h4007FF) begin s = 5'b01000; off = e & 24'h7FF; tag = "R5"; end
        else begin s = 5'b10000; off = e; tag = "R8"; end
        if (!m) tag = "R2";
        we = wr && (s == 5'b00010 || s == 5'b00100 || s == 5'b01000);
        if (!wr && s == 5'b10000) rd = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFFFFFF;
        else rd = 32'h0;
    endtask

    task automatic drive(input logic [23:0] a, input logic [1:0] sz, input bit wr, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
        #1;
    endtask

    task automatic reg_write(input logic [23:0] a, input logic [1:0] sz, input logic [31:0] wd);
        drive(a, sz, 1'b1, wd);
        idle();
    endtask

    task automatic probe(input logic [23:0] a, input bit m, input logic [1:0] sz, input bit wr);
        logic [4:0] s; logic [23:0] off; bit we; logic [31:0] rd; string tag;
        model(a, m, sz, wr, s, off, we, rd, tag);
        drive(a, sz, wr, 32'h0);
        chk(sel_o == s && region_off_o == off && mem_we_o == we && rd_data_o == rd, tag,
            {sel_o, region_off_o, mem_we_o, rd_data_o[2:0]}, {s, off, we, rd[2:0]});
        if (rd_data_o != rd) chk(1'b0, "R8", 64'(rd_data_o), 64'(rd));
    endtask

    // overlay state observed at the ports: address 0x000100 selects RAM only when map-enable is 1
    task automatic expect_map(input bit m, input string req);
        drive(24'h000100, 2'd1, 1'b0, 32'h0);
        chk(sel_o == (m ? 5'b00010 : 5'b00001), req, 64'(sel_o), m ? 64'h2 : 64'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk(led_n_o == 4'hF, "R1", 64'(led_n_o), 64'hF);
        expect_map(1'b0, "R1");
        // R9 idle
        idle();
        chk(sel_o == 5'b0 && mem_we_o == 1'b0, "R9", 64'(sel_o), 0);

        // R10: LED write while overlay active goes to 0xCA0000 (I/O)
        reg_write(24'h4A0000, 2'd1, 32'h0000_0000);
        chk(led_n_o == 4'hF, "R10", 64'(led_n_o), 64'hF);

        // Sweep with overlay active (R2)
        for (int i = 0; i < 4096; i++)
            probe(24'(i << 12) | 24'((i * 173) & 12'hFFF), 1'b0, 2'(i % 3), i[0]);
        idle();

        // R6: word write with bit 15 clear, bit 7 set -> stays 0
        reg_write(24'hE43000, 2'd1, 32'h0000_0080);
        expect_map(1'b0, "R6");
        // R6: byte write bit 7
        reg_write(24'hE43000, 2'd0, 32'h0000_0080);
        expect_map(1'b1, "R6");

        // Boundaries with overlay clear
        probe(24'h07FFFF, 1'b1, 2'd0, 1'b0);
        probe(24'h080000, 1'b1, 2'd1, 1'b0);
        probe(24'h3FFFFF, 1'b1, 2'd2, 1'b0);
        probe(24'h400000, 1'b1, 2'd0, 1'b1);
        probe(24'h4007FF, 1'b1, 2'd0, 1'b0);
        probe(24'h400800, 1'b1, 2'd1, 1'b0);
        probe(24'h41FFFF, 1'b1, 2'd0, 1'b0);
        probe(24'h420000, 1'b1, 2'd1, 1'b1);
        probe(24'h427FFF, 1'b1, 2'd0, 1'b0);
        probe(24'h428000, 1'b1, 2'd3, 1'b0);
        probe(24'h7FFFFF, 1'b1, 2'd0, 1'b0);
        probe(24'h800000, 1'b1, 2'd2, 1'b1);
        probe(24'hBFFFFF, 1'b1, 2'd0, 1'b0);
        probe(24'hC00000, 1'b1, 2'd1, 1'b0);
        idle();

        // R7 LED lanes by size
        reg_write(24'h4A0000, 2'd1, 32'h0000_0A55);
        chk(led_n_o == 4'hA, "R7 word", 64'(led_n_o), 64'hA);
        reg_write(24'h4A0000, 2'd0, 32'h0000_0F05);
        chk(led_n_o == 4'h5, "R7 byte", 64'(led_n_o), 64'h5);
        reg_write(24'h4A0000, 2'd2, 32'h0C00_0F0F);
        chk(led_n_o == 4'hC, "R7 long", 64'(led_n_o), 64'hC);
        // R10 neighbour address and memory writes leave the LEDs alone
        reg_write(24'h4A0002, 2'd1, 32'h0000_0300);
        chk(led_n_o == 4'hC, "R10", 64'(led_n_o), 64'hC);
        reg_write(24'h000000, 2'd2, 32'h0000_0000);
        chk(led_n_o == 4'hC, "R10", 64'(led_n_o), 64'hC);

        // Sweep with overlay clear
        for (int i = 0; i < 4096; i++)
            probe(24'(i << 12) | 24'((i * 173) & 12'hFFF), 1'b1, 2'(i % 3), i[0]);
        idle();
        chk(led_n_o == 4'hC, "R10", 64'(led_n_o), 64'hC);

        // R6 long uses bit 15; byte ignores bit 15
        reg_write(24'hE43000, 2'd0, 32'h0000_8000);
        expect_map(1'b0, "R6");
        reg_write(24'hE43000, 2'd2, 32'h0000_8000);
        expect_map(1'b1, "R6");
        reg_write(24'hE43000, 2'd3, 32'h0000_0080);
        expect_map(1'b0, "R6");
        reg_write(24'hE43000, 2'd1, 32'h0000_8000);
        expect_map(1'b1, "R6");
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule